// File: doc/BRIEF.md
# Block-RAM-Backed Synchronous FIFO

This block is a single-clock first-in first-out queue. Its storage is a simple dual-port memory coded so that synthesis can map it onto on-chip block RAM. The coding follows the usual rules for that mapping: one clock, whole-word writes on the clock edge, a registered synchronous read, and no reset on the array. Words enter at the tail through a valid/ready write channel and leave from the head when the consumer raises a pop request. The popped word comes out of the memory's output register one cycle later, together with a single-cycle valid pulse.

The write side uses back-pressure. `wr_ready` is high exactly when the queue is not full, and a word is taken on any clock edge where `wr_valid` and `wr_ready` are both high. If a producer raises `wr_valid` while `wr_ready` is low, the word is discarded rather than held, and a sticky overflow flag records the loss. The read side has no back-pressure. The consumer asks with `rd_req`, and the block answers only when it holds data. A request made while the queue is empty is ignored and sets a sticky underflow flag.

The storage is built as read-before-write. The FIFO's own pointer rules never let a write and a read hit the same entry in one cycle, so this choice cannot show up at the ports. A word pushed into an empty queue can be popped on the very next cycle and comes out correctly.

Top module: `bram_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `count`=0, `wr_ready`=1, `rd_valid`=0, `overflow`=0 and `underflow`=0.
- R2: Words are popped in the order in which they were accepted.
- R3: `rd_valid` is 1 in the cycle after each accepted pop, with the popped word on `rd_data`. In every other cycle it is 0.
- R4: When `count` reaches 2**ADDR_W, `full`=1 and `wr_ready`=0. A push offered then is dropped, and the stored contents are unchanged.
- R5: A push offered while full sets `overflow`, which stays 1 until reset.
- R6: A pop request while empty produces no `rd_valid` and leaves `count` at 0. It sets `underflow`, which stays 1 until reset.
- R7: An accepted push and an accepted pop in the same cycle leave `count` unchanged.
- R8: A word pushed into an empty FIFO and popped on the next cycle is returned as that word.
- R9: `count` equals the accepted pushes minus the accepted pops. `empty` is 1 exactly when `count` is 0, and `full` and `empty` are never both 1.
- R10: The order of words is preserved across pointer wrap-around, when total traffic exceeds the depth several times.
- R11: While full, a push together with a pop accepts only the pop, so `count` drops by one. `wr_ready` depends only on `full`.
- R12: `rd_data` keeps its value in every cycle without an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for storage, pointers and output register |
| rst_n | input | 1 | Asynchronous active-low reset of pointers and flags (not the array) |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | High when not full; a push is taken when both are high |
| wr_data | input | DATA_W | Word to push |
| rd_req | input | 1 | Consumer asks for the head word |
| rd_valid | output | 1 | One-cycle pulse after an accepted pop |
| rd_data | output | DATA_W | Registered popped word, held between pops |
| full | output | 1 | Occupancy equals 2**ADDR_W |
| empty | output | 1 | Occupancy is zero |
| count | output | ADDR_W+1 | Current occupancy |
| overflow | output | 1 | Sticky: a push was offered while full |
| underflow | output | 1 | Sticky: a pop was requested while empty |

## Verification
The bench builds the FIFO with ADDR_W=4 and DATA_W=8, which gives 16 entries instead of the default 512. At that depth, filling to full, dropping pushes at full, and draining back to empty each take only a few dozen cycles. The pointers also wrap several times within one stream, so the wrap-bit logic behind full/empty detection and the one-cycle read latency are exercised at every boundary. Every cycle is compared against a queue model for data, valid pulses, count and both sticky flags.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // Operations accepted in the current cycle, shared by control and top.
  typedef struct packed {
    logic push;
    logic pop;
  } fifo_ops_t;
endpackage

// File: rtl/fifo_sdp_ram.sv
// Simple dual-port storage: synchronous whole-word write, registered
// synchronous read (read-before-write), no reset on the array.
module fifo_sdp_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= re;
  end
endmodule

// File: rtl/fifo_ptr.sv
// Wrapping pointer one bit wider than the address.
module fifo_ptr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              rd_req,
  output fifo_ops_t         ops,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W:0]   count,
  output logic              ovf,
  output logic              unf
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1) << ADDR_W;

  logic [PW-1:0] wptr, rptr;

  fifo_ptr #(.W(PW)) u_wptr (.clk(clk), .rst_n(rst_n), .adv(ops.push), .ptr(wptr));
  fifo_ptr #(.W(PW)) u_rptr (.clk(clk), .rst_n(rst_n), .adv(ops.pop),  .ptr(rptr));

  always_comb begin
    empty    = (wptr == rptr);
    full     = (wptr[ADDR_W] != rptr[ADDR_W]) &&
               (wptr[ADDR_W-1:0] == rptr[ADDR_W-1:0]);
    count    = wptr - rptr;
    waddr    = wptr[ADDR_W-1:0];
    raddr    = rptr[ADDR_W-1:0];
    ops.push = wr_req & ~full;
    ops.pop  = rd_req & ~empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (wr_req && full)  ovf <= 1'b1;
      if (rd_req && empty) unf <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH); // R4
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R9
  AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ops.push && ops.pop) |=> $stable(count)); // R7
  AST_FULL_PUSH_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req) |=> (count <= $past(count))); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R5
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf); // R6
endmodule

// File: rtl/bram_fifo.sv
module bram_fifo
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W:0]   count,
  output logic              overflow,
  output logic              underflow
);
  fifo_ops_t         ops;
  logic [ADDR_W-1:0] waddr, raddr;

  fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_valid), .rd_req(rd_req),
    .ops(ops), .waddr(waddr), .raddr(raddr), .full(full), .empty(empty),
    .count(count), .ovf(overflow), .unf(underflow)
  );

  fifo_sdp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(ops.push), .waddr(waddr), .wdata(wr_data),
    .re(ops.pop), .raddr(raddr), .rdata(rd_data), .rvalid(rd_valid)
  );

  assign wr_ready = ~full;

  AST_VALID_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !empty) |=> rd_valid); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && !empty) |=> !rd_valid); // R3
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> (!rd_valid && underflow)); // R6
  AST_EMPTY_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (count == '0)); // R9
endmodule

// File: tb/test_bram_fifo.sv
module test_bram_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, full, empty, overflow, underflow;
  logic [DW-1:0] rd_data;
  logic [AW:0] count;

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];
  logic m_ovf = 1'b0, m_unf = 1'b0;
  logic [DW-1:0] last_word = '0;
  logic popped_once = 1'b0;
  logic last_popped_ok;
  logic [DW-1:0] last_pop_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  bram_fifo #(.ADDR_W(AW), .DATA_W(DW)) i_bram_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .full(full), .empty(empty), .count(count),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock cycle against the queue model, with per-cycle checks.
  task automatic step(input logic push, input logic [DW-1:0] d, input logic pop);
    int n;
    logic ep, eo;
    @(negedge clk);
    wr_valid = push; wr_data = d; rd_req = pop;
    #1;
    n = q.size();
    chk("R11 wr_ready before edge", 32'(wr_ready), 32'(n < DEPTH));
    ep = push && (n < DEPTH);
    eo = pop && (n > 0);
    if (push && n == DEPTH) m_ovf = 1'b1;
    if (pop && n == 0) m_unf = 1'b1;
    @(posedge clk);
    #1;
    last_popped_ok = eo;
    if (eo) begin
      last_word = q.pop_front();
      popped_once = 1'b1;
      last_pop_word = last_word;
    end
    if (ep) q.push_back(d);
    chk("R3 rd_valid", 32'(rd_valid), 32'(eo));
    if (eo) chk("R2 rd_data order", 32'(rd_data), 32'(last_word));
    else if (popped_once) chk("R12 rd_data held", 32'(rd_data), 32'(last_word));
    chk("R9 count", 32'(count), 32'(q.size()));
    chk("R9 empty", 32'(empty), 32'(q.size() == 0));
    chk("R4 full", 32'(full), 32'(q.size() == DEPTH));
    chk("R5 overflow", 32'(overflow), 32'(m_ovf));
    chk("R6 underflow", 32'(underflow), 32'(m_unf));
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 count", 32'(count), 32'd0);
    chk("R1 wr_ready", 32'(wr_ready), 32'd1);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    chk("R1 overflow", 32'(overflow), 32'd0);
    chk("R1 underflow", 32'(underflow), 32'd0);
  endtask

  task automatic t_push_then_pop();
    step(1'b1, 8'hA5, 1'b0);
    step(1'b0, '0, 1'b1);
    chk("R8 next-cycle pop returns new word", 32'(rd_data), 32'h0A5);
    idle();
  endtask

  task automatic t_order();
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'h10 + i * 3), 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R2 sequence", 32'(rd_data), 32'(8'h10 + i * 3));
    end
    idle(); idle();
  endtask

  task automatic t_underflow();
    step(1'b0, '0, 1'b1);
    chk("R6 no valid on empty pop", 32'(rd_valid), 32'd0);
    chk("R6 count stays 0", 32'(count), 32'd0);
    chk("R6 underflow set", 32'(underflow), 32'd1);
    idle();
    chk("R6 underflow sticky", 32'(underflow), 32'd1);
  endtask

  task automatic t_fill_drop();
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h40 + i), 1'b0);
    chk("R4 full at depth", 32'(full), 32'd1);
    chk("R4 wr_ready low", 32'(wr_ready), 32'd0);
    step(1'b1, 8'hEE, 1'b0);
    chk("R4 dropped push keeps count", 32'(count), 32'(DEPTH));
    chk("R5 overflow set", 32'(overflow), 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R4 contents unchanged", 32'(rd_data), 32'(8'(8'h40 + i)));
    end
    idle();
    chk("R4 dropped word absent", 32'(empty), 32'd1);
    chk("R5 overflow still set", 32'(overflow), 32'd1);
  endtask

  task automatic t_simul();
    step(1'b1, 8'h01, 1'b0);
    step(1'b1, 8'h02, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 8'(8'h20 + i), 1'b1);
      chk("R7 count steady", 32'(count), 32'd2);
    end
    while (q.size() > 0) step(1'b0, '0, 1'b1);
    idle();
  endtask

  task automatic t_full_pushpop();
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h80 + i), 1'b0);
    step(1'b1, 8'h77, 1'b1);
    chk("R11 pop only at full", 32'(count), 32'(DEPTH - 1));
    chk("R11 popped head", 32'(rd_data), 32'h080);
    while (q.size() > 0) step(1'b0, '0, 1'b1);
    idle();
  endtask

  task automatic t_wrap();
    int sent = 0;
    for (int c = 0; c < DEPTH * 4; c++) begin
      logic pu, po;
      pu = (c % 3) != 2;
      po = (c > 4) && ((c % 4) != 0);
      step(pu, 8'(sent * 13 + 5), po);
      if (pu && q.size() > 0) sent++;
    end
    while (q.size() > 0) step(1'b0, '0, 1'b1);
    idle();
    chk("R10 wrap drained empty", 32'(empty), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_push_then_pop();
    t_order();
    t_underflow();
    t_fill_drop();
    t_simul();
    t_full_pushpop();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule